// File: doc/BRIEF.md
# Sequence-Unlocked Watchdog Timer

This block is a hardware watchdog for a small controller. Once it has been started, software must service it regularly. If software stops, the block emits a reset request of fixed length that returns the whole chip to a known state. The block stays idle after chip reset. Software starts it, and later restarts its count, by writing a two-byte key to a dedicated key register. Nothing short of a chip reset, or the watchdog's own reset pulse, stops it once it runs.

The time base is the oscillator clock. It passes through a selectable divider, then a prescaler, then a programmable counter. A 3-bit exponent, held in a separate program register, sets the time-out. When the count expires, a divide-by-six pulse stretcher drives the reset request for a fixed number of oscillator cycles. While that pulse is high, the watchdog returns to its chip-reset state.

The register port is a simple write port. A select line picks the program register (0) or the key register (1). An 8-bit data byte and a write strobe complete it, and a write takes effect at the rising clock edge where the strobe is high.

Top module: `seq_watchdog`

## Requirements
- R1: After chip reset (rst_n low), the reset request is low, the watchdog is disabled and the exponent is 0. No reset request appears until the watchdog is started.
- R2: A key-register write of 1Eh, followed directly by a key-register write of E1h, clears the prescaler and counter and enables the watchdog. Program-register writes in between do not matter.
- R3: Any other key-register write discards a pending first key. A write of 1Eh always re-arms the first step, so 1Eh, 1Eh, E1h starts the watchdog.
- R4: Repeating the key sequence while the watchdog runs restarts the full time-out from the E1h write.
- R5: The time-out is 2^PRE_W × 2^E watchdog ticks, where E is program-register data bits 2:0. E = 7 uses the full overflow of the 7-bit counter. The reset request rises at the clock edge that closes the cycle of the last tick.
- R6: With clk_sel = 1, or with dbl_speed = 0, a tick occurs every second oscillator cycle, starting in the second cycle after the E1h edge. With clk_sel = 0 and dbl_speed = 1, a tick occurs every cycle, starting in the first cycle after that edge.
- R7: The reset request stays high for exactly 96 oscillator cycles (16 periods of a divide-by-6 clock).
- R8: While the reset request is high, the watchdog is cleared and disabled and the exponent returns to 0. Register writes are ignored during that time.
- R9: The program register can be written at any time. A new exponent is used at the next prescaler carry: expiry occurs at the first carry at which the counter's low E bits are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| clk_sel | input | 1 | 1: tick clock fixed at oscillator/2 |
| dbl_speed | input | 1 | 1: double-speed mode (undivided ticks when clk_sel = 0) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: program register, 1: key register |
| wr_data | input | 8 | Write data byte |
| wdt_rst | output | 1 | Internal reset request pulse |

## Verification
The bench measures the exact cycle count from the E1h edge to the reset request for every mode combination, including the clamped exponent 7. An off-by-one in the tick phase or the counter tap shows up there as a wrong count. It attacks the key decoder with a stray byte between the keys and with a doubled first key. A decoder that keeps a stale arm would start on the wrong sequence, and one that fails to re-arm would never start. Exponent changes are made mid-count, and key writes are made during the pulse. A design that latched the exponent only at start, or that kept its state through its own reset pulse, would fire at the wrong time or fire a second time.

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
  parameter int PRE_W       = 14,
  parameter int CNT_W       = 7,
  parameter int WTO_W       = 3,
  parameter int DIV         = 6,
  parameter int PULSE_TICKS = 16,
  parameter logic [7:0] KEY1 = 8'h1E,
  parameter logic [7:0] KEY2 = 8'hE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_sel,
  input  logic       dbl_speed,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       wdt_rst
);
  localparam int DW = $clog2(DIV);
  localparam int PW = $clog2(PULSE_TICKS);

  logic             en, armed, ph, pulse;
  logic [WTO_W-1:0] wto;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, mask;
  logic [DW-1:0]    div;
  logic [PW-1:0]    pcnt;

  wire fast      = dbl_speed & ~clk_sel;
  wire tick      = en & (fast | ph);
  wire pre_carry = tick & (&pre);
  wire expire    = pre_carry & ((cnt & mask) == mask);
  wire key_wr    = wr_en & wr_sel;
  wire kick      = key_wr & armed & (wr_data == KEY2);

  always_comb
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(wto));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; armed <= 1'b0; ph <= 1'b0; pulse <= 1'b0;
      wto <= '0; pre <= '0; cnt <= '0; div <= '0; pcnt <= '0;
    end else if (pulse) begin
      en <= 1'b0; armed <= 1'b0; ph <= 1'b0;
      wto <= '0; pre <= '0; cnt <= '0;
      if (div == DW'(DIV - 1)) begin
        div <= '0;
        if (pcnt == PW'(PULSE_TICKS - 1)) pulse <= 1'b0;
        else pcnt <= pcnt + 1'b1;
      end else begin
        div <= div + 1'b1;
      end
    end else begin
      if (en)        ph  <= ~ph;
      if (tick)      pre <= pre + 1'b1;
      if (pre_carry) cnt <= cnt + 1'b1;
      if (wr_en && !wr_sel) wto <= wr_data[WTO_W-1:0];
      if (key_wr)    armed <= (wr_data == KEY1);
      if (kick) begin
        en <= 1'b1; ph <= 1'b0; pre <= '0; cnt <= '0;
      end
      if (expire) begin
        pulse <= 1'b1; div <= '0; pcnt <= '0; en <= 1'b0; armed <= 1'b0;
      end
    end
  end

  assign wdt_rst = pulse;
endmodule

// File: rtl/seq_watchdog_chk.sv
module seq_watchdog_chk #(
  parameter int WTO_W     = 3,
  parameter int PULSE_LEN = 96,
  parameter logic [7:0] KEY1 = 8'h1E,
  parameter logic [7:0] KEY2 = 8'hE1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [7:0]       wr_data,
  input logic             wdt_rst,
  input logic             en,
  input logic [WTO_W-1:0] wto
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_cnt <= '0;
    else if (wdt_rst) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wdt_rst) |=> !wdt_rst);

  p_key_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data == KEY2 && !wdt_rst &&
     $past(wr_en && wr_sel && wr_data == KEY1 && !wdt_rst)) |=> (en || wdt_rst));

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (hi_cnt == 16'(PULSE_LEN)));

  p_off_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> !en);

  p_prog_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wdt_rst) |=> (wto == $past(wr_data[WTO_W-1:0])));
endmodule

bind seq_watchdog seq_watchdog_chk #(
  .WTO_W(WTO_W), .PULSE_LEN(DIV * PULSE_TICKS), .KEY1(KEY1), .KEY2(KEY2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wdt_rst(wdt_rst), .en(en), .wto(wto)
);

// File: tb/sim_seq_watchdog.sv
`timescale 1ns/1ps
module sim_seq_watchdog;
  logic clk = 1'b0, rst_n = 1'b0, clk_sel = 1'b0, dbl_speed = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wdt_rst;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  seq_watchdog #(.PRE_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .dbl_speed(dbl_speed),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wdt_rst(wdt_rst));

  // {clk_sel, dbl_speed, exponent[2:0], cycles from E1h edge to request[15:0]}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 1'b1, 3'd0, 16'd16},   {1'b0, 1'b0, 3'd0, 16'd32},
    {1'b1, 1'b1, 3'd0, 16'd32},   {1'b1, 1'b0, 3'd1, 16'd64},
    {1'b0, 1'b1, 3'd3, 16'd128},  {1'b0, 1'b0, 3'd2, 16'd128},
    {1'b0, 1'b1, 3'd7, 16'd2048}, {1'b0, 1'b0, 3'd5, 16'd1024}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic kick();
    wr(1'b1, 8'h1E); wr(1'b1, 8'hE1);
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int k = 1; k <= 5000; k++) begin
      @(negedge clk);
      if (wdt_rst) begin n = k; return; end
    end
    n = -1;
  endtask

  task automatic width(output int w);
    w = 1;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (wdt_rst) w++; else return;
    end
  endtask

  task automatic quiet(input int cyc, output bit seen);
    seen = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (wdt_rst) seen = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n, w;
    bit seen;
    repeat (3) @(negedge clk);
    chk(wdt_rst == 1'b0, "R1 request low in reset", wdt_rst, 0);
    rst_n = 1'b1;
    quiet(3000, seen);
    chk(!seen, "R1 idle after reset", seen, 0);

    for (int i = 0; i < 8; i++) begin
      clk_sel = VEC[i][20]; dbl_speed = VEC[i][19];
      wr(1'b0, {5'b0, VEC[i][18:16]});
      kick();
      measure(n);
      chk(n == int'(VEC[i][15:0]), $sformatf("R5/R6 timeout vec %0d", i), n, int'(VEC[i][15:0]));
      width(w);
      chk(w == 96, $sformatf("R7 pulse width vec %0d", i), w, 96);
    end

    clk_sel = 1'b0; dbl_speed = 1'b1;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h1E); wr(1'b1, 8'h55); wr(1'b1, 8'hE1);
    quiet(300, seen);
    chk(!seen, "R3 stray byte discards key", seen, 0);
    wr(1'b1, 8'hE1);
    quiet(300, seen);
    chk(!seen, "R3 lone second key ignored", seen, 0);

    wr(1'b1, 8'h1E); wr(1'b1, 8'h1E); wr(1'b1, 8'hE1);
    measure(n);
    chk(n == 16, "R3 doubled first key re-arms", n, 16);
    width(w);

    wr(1'b0, 8'h03);
    kick();
    repeat (60) @(negedge clk);
    chk(wdt_rst == 1'b0, "R4 no request before restart", wdt_rst, 0);
    kick();
    measure(n);
    chk(n == 128, "R4 restart reloads full count", n, 128);
    width(w);

    wr(1'b0, 8'h03);
    kick();
    n = -1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (k == 4) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00; end
      if (k == 5) wr_en = 1'b0;
      if (wdt_rst) begin n = k; break; end
    end
    chk(n == 16, "R9 exponent change mid-count", n, 16);
    width(w);

    wr(1'b0, 8'h00);
    kick();
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    quiet(300, seen);
    chk(!seen, "R1 chip reset stops watchdog", seen, 0);

    wr(1'b0, 8'h02);
    kick();
    measure(n);
    chk(n == 64, "R5 exponent 2 fast mode", n, 64);
    wr(1'b0, 8'h03); wr(1'b1, 8'h1E); wr(1'b1, 8'hE1);
    while (wdt_rst) @(negedge clk);
    quiet(300, seen);
    chk(!seen, "R8 writes during pulse ignored", seen, 0);
    kick();
    measure(n);
    chk(n == 16, "R8 pulse clears exponent", n, 16);
    width(w);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule